// File: doc/BRIEF.md
# FIFO-Threshold Bus Request Controller

This controller decides, cycle by cycle, whether a bus-master engine should ask for the shared bus. It serves two independent transfer directions. In the inbound (read) direction, bus data is pulled into a local FIFO. In the outbound (write) direction, local FIFO data is pushed onto the bus. Before the bus is granted, each direction raises its request only when its FIFO has crossed a selectable threshold. One threshold is a single DWORD. The other is a batch of at least four DWORDs: free slots for the read direction, filled entries for the write direction.

After a grant has been accepted, the threshold no longer matters. A read burst runs while any slot is free, and a write burst runs while any data is left. The burst stops when the FIFO fills (read) or drains (write), when mastering is switched off, or when the grant goes away. After any of these, the controller is back in its pre-grant state and the threshold decides again.

Mastering enable comes from register bits or from local enable pins, selected by a mode input. Each request is also gated by a permit from the address and count sequencer. The block carries no data stream, so every pin is a plain level with no valid/ready handshake.

Top module: `brq_ctrl`

## Requirements
- R1: While `rst_n` is low, `rd_req`, `wr_req`, `bus_req`, `rd_cont` and `wr_cont` are all 0, and the controller leaves reset with no direction holding the bus.
- R2: With `rd_deep`=0, the idle read direction requests whenever free slots (8 minus `rd_fill`) are at least 1.
- R3: With `rd_deep`=1, the idle read direction requests only when free slots are 4 or more.
- R4: With `wr_deep`=0, the idle write direction requests whenever `wr_fill` is at least 1.
- R5: With `wr_deep`=1, the idle write direction requests only when `wr_fill` is 4 or more.
- R6: With `local_mode`=1, a direction is enabled by its local enable pin and its register bit has no effect. With `local_mode`=0, the register bit enables it and the local pin has no effect.
- R7: A low permit input (`rd_permit` / `wr_permit`) holds that direction's request low.
- R8: A direction whose request is high when `gnt` is sampled high by a rising edge owns the bus from that edge. While it owns the bus and `gnt` stays high, its request and continue outputs stay high regardless of the threshold: read until `rd_fill` reaches 8, write until `wr_fill` reaches 0.
- R9: An owning direction drops its request and continue output in the same cycle that its FIFO becomes full (read) or empty (write), or that it is disabled.
- R10: When `gnt` falls during a burst, ownership is released at the next edge, and the direction re-requests only when its threshold is met again.
- R11: If both directions request when the grant is taken, the read direction wins. While either direction owns the bus, the other direction's request is held low.
- R12: `bus_req` is high exactly when `rd_req` or `wr_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_mode | input | 1 | 1: local enable pins govern mastering; 0: register bits do |
| rd_reg_en | input | 1 | Register enable, read direction |
| wr_reg_en | input | 1 | Register enable, write direction |
| rd_loc_en | input | 1 | Local enable pin, read direction |
| wr_loc_en | input | 1 | Local enable pin, write direction |
| rd_permit | input | 1 | Sequencer permit, read direction |
| wr_permit | input | 1 | Sequencer permit, write direction |
| rd_deep | input | 1 | Read threshold: 0 = one free slot, 1 = four free slots |
| wr_deep | input | 1 | Write threshold: 0 = one entry, 1 = four entries |
| rd_fill | input | CNT_W | Occupancy of the inbound FIFO |
| wr_fill | input | CNT_W | Occupancy of the outbound FIFO |
| gnt | input | 1 | Bus grant |
| rd_req | output | 1 | Read-direction bus request |
| wr_req | output | 1 | Write-direction bus request |
| bus_req | output | 1 | Merged bus request |
| rd_cont | output | 1 | Read burst may continue this cycle |
| wr_cont | output | 1 | Write burst may continue this cycle |

## Verification
Requests and continue outputs are combinational in the current inputs and in the ownership state. A change in fill, enable, permit or threshold select therefore shows up in the same cycle, while ownership, and with it the post-grant behaviour, changes only at the rising edge that samples a grant together with a request. The bench drives inputs 1 ns after each rising edge. It compares every output at the falling edge against a behavioural model whose owner variable is updated on the rising edge. Each result is thus checked in the cycle it becomes due, never one edge early or late.

// File: rtl/brq_pkg.sv
`timescale 1ns/1ps
package brq_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RD   = 2'd1,
    OWN_WR   = 2'd2
  } own_t;

  localparam int DIR_RD = 0;
  localparam int DIR_WR = 1;
  localparam int N_DIR  = 2;
endpackage

// File: rtl/brq_dir_gate.sv
`timescale 1ns/1ps
// Per-direction qualification: enable source, permit, and the level that is
// compared against the threshold (free slots for inbound, entries for outbound).
module brq_dir_gate #(
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 4,
  parameter int DEEP_MIN = 4,
  parameter bit IS_READ  = 1'b1
) (
  input  logic             local_mode,
  input  logic             reg_en,
  input  logic             loc_en,
  input  logic             permit,
  input  logic             deep,
  input  logic [CNT_W-1:0] fill,
  output logic             pre_ok,
  output logic             live
);
  localparam int LW = CNT_W + 1;
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [LW-1:0] DEEP_L  = LW'(DEEP_MIN);

  logic [LW-1:0] fill_x;
  logic [LW-1:0] level;
  logic          on;

  assign fill_x = {1'b0, fill};

  generate
    if (IS_READ) begin : g_free
      always_comb level = (fill_x >= DEPTH_L) ? '0 : (DEPTH_L - fill_x);
    end else begin : g_used
      always_comb level = (fill_x > DEPTH_L) ? DEPTH_L : fill_x;
    end
  endgenerate

  always_comb begin
    on     = (local_mode ? loc_en : reg_en) & permit;
    live   = on & (level != '0);
    pre_ok = on & (deep ? (level >= DEEP_L) : (level != '0));
  end
endmodule

// File: rtl/brq_owner.sv
`timescale 1ns/1ps
// Ownership tracking: threshold-qualified requests before grant,
// run-to-limit requests while a direction holds the bus.
module brq_owner
  import brq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  input  logic rd_pre,
  input  logic rd_live,
  input  logic wr_pre,
  input  logic wr_live,
  output logic rd_req,
  output logic wr_req,
  output logic rd_cont,
  output logic wr_cont
);
  own_t own_q, own_d;

  always_comb begin
    rd_req  = rst_n & ((own_q == OWN_RD) ? rd_live : ((own_q == OWN_NONE) & rd_pre));
    wr_req  = rst_n & ((own_q == OWN_WR) ? wr_live : ((own_q == OWN_NONE) & wr_pre));
    rd_cont = rst_n & (own_q == OWN_RD) & gnt & rd_live;
    wr_cont = rst_n & (own_q == OWN_WR) & gnt & wr_live;
  end

  always_comb begin
    own_d = own_q;
    unique case (own_q)
      OWN_NONE: begin
        if (gnt && rd_req)      own_d = OWN_RD;
        else if (gnt && wr_req) own_d = OWN_WR;
      end
      OWN_RD:  if (!gnt || !rd_live) own_d = OWN_NONE;
      OWN_WR:  if (!gnt || !wr_live) own_d = OWN_NONE;
      default: own_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_d;
  end
endmodule

// File: rtl/brq_ctrl.sv
`timescale 1ns/1ps
module brq_ctrl
  import brq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 4,
  parameter int DEEP_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             local_mode,
  input  logic             rd_reg_en,
  input  logic             wr_reg_en,
  input  logic             rd_loc_en,
  input  logic             wr_loc_en,
  input  logic             rd_permit,
  input  logic             wr_permit,
  input  logic             rd_deep,
  input  logic             wr_deep,
  input  logic [CNT_W-1:0] rd_fill,
  input  logic [CNT_W-1:0] wr_fill,
  input  logic             gnt,
  output logic             rd_req,
  output logic             wr_req,
  output logic             bus_req,
  output logic             rd_cont,
  output logic             wr_cont
);
  logic [N_DIR-1:0] reg_en_v, loc_en_v, permit_v, deep_v, pre_v, live_v;
  logic [CNT_W-1:0] fill_v [N_DIR];

  assign reg_en_v = {wr_reg_en, rd_reg_en};
  assign loc_en_v = {wr_loc_en, rd_loc_en};
  assign permit_v = {wr_permit, rd_permit};
  assign deep_v   = {wr_deep,   rd_deep};
  assign fill_v[DIR_RD] = rd_fill;
  assign fill_v[DIR_WR] = wr_fill;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    brq_dir_gate #(
      .DEPTH   (DEPTH),
      .CNT_W   (CNT_W),
      .DEEP_MIN(DEEP_MIN),
      .IS_READ (d == DIR_RD)
    ) u_gate (
      .local_mode(local_mode),
      .reg_en    (reg_en_v[d]),
      .loc_en    (loc_en_v[d]),
      .permit    (permit_v[d]),
      .deep      (deep_v[d]),
      .fill      (fill_v[d]),
      .pre_ok    (pre_v[d]),
      .live      (live_v[d])
    );
  end

  brq_owner u_owner (
    .clk    (clk),
    .rst_n  (rst_n),
    .gnt    (gnt),
    .rd_pre (pre_v[DIR_RD]),
    .rd_live(live_v[DIR_RD]),
    .wr_pre (pre_v[DIR_WR]),
    .wr_live(live_v[DIR_WR]),
    .rd_req (rd_req),
    .wr_req (wr_req),
    .rd_cont(rd_cont),
    .wr_cont(wr_cont)
  );

  assign bus_req = rd_req | wr_req;
endmodule

// File: rtl/brq_ctrl_chk.sv
`timescale 1ns/1ps
module brq_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             local_mode,
  input logic             rd_reg_en,
  input logic             wr_reg_en,
  input logic             rd_loc_en,
  input logic             wr_loc_en,
  input logic             rd_permit,
  input logic             wr_permit,
  input logic [CNT_W-1:0] rd_fill,
  input logic [CNT_W-1:0] wr_fill,
  input logic             gnt,
  input logic             rd_req,
  input logic             wr_req,
  input logic             rd_cont,
  input logic             wr_cont
);
  assert_rd_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_fill) >= DEPTH) |-> !rd_req);
  assert_wr_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fill == '0) |-> !wr_req);
  assert_rd_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (local_mode ? rd_loc_en : rd_reg_en));
  assert_wr_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (local_mode ? wr_loc_en : wr_reg_en));
  assert_permit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_permit |-> !rd_req) and (!wr_permit |-> !wr_req));
  assert_rd_cont_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cont |-> $past(gnt && rd_req));
  assert_wr_cont_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cont |-> $past(gnt && wr_req));
  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cont |-> !wr_req) and (wr_cont |-> !rd_req));
endmodule

bind brq_ctrl brq_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .local_mode(local_mode),
  .rd_reg_en(rd_reg_en), .wr_reg_en(wr_reg_en),
  .rd_loc_en(rd_loc_en), .wr_loc_en(wr_loc_en),
  .rd_permit(rd_permit), .wr_permit(wr_permit),
  .rd_fill(rd_fill), .wr_fill(wr_fill), .gnt(gnt),
  .rd_req(rd_req), .wr_req(wr_req), .rd_cont(rd_cont), .wr_cont(wr_cont)
);

// File: tb/brq_ctrl_test.sv
`timescale 1ns/1ps
module brq_ctrl_test;
  localparam int DEPTH = 8;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, local_mode, rd_reg_en, wr_reg_en, rd_loc_en, wr_loc_en;
  logic rd_permit, wr_permit, rd_deep, wr_deep, gnt;
  logic [CNT_W-1:0] rd_fill, wr_fill;
  logic rd_req, wr_req, bus_req, rd_cont, wr_cont;

  brq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .local_mode(local_mode),
    .rd_reg_en(rd_reg_en), .wr_reg_en(wr_reg_en),
    .rd_loc_en(rd_loc_en), .wr_loc_en(wr_loc_en),
    .rd_permit(rd_permit), .wr_permit(wr_permit),
    .rd_deep(rd_deep), .wr_deep(wr_deep),
    .rd_fill(rd_fill), .wr_fill(wr_fill), .gnt(gnt),
    .rd_req(rd_req), .wr_req(wr_req), .bus_req(bus_req),
    .rd_cont(rd_cont), .wr_cont(wr_cont)
  );

  int total = 0;
  int bad = 0;
  string tag = "R1";
  int own_m = 0; // 0 idle, 1 read holds bus, 2 write holds bus
  bit done = 0;

  // behavioural expectations from the requirements
  int  free_m, used_m;
  bit  rd_on_m, wr_on_m, rd_pre_m, rd_live_m, wr_pre_m, wr_live_m;
  bit  e_rd, e_wr, e_rc, e_wc;
  always @* begin
    rd_on_m   = (local_mode ? rd_loc_en : rd_reg_en) && rd_permit;
    wr_on_m   = (local_mode ? wr_loc_en : wr_reg_en) && wr_permit;
    free_m    = DEPTH - int'(rd_fill);
    if (free_m < 0) free_m = 0;
    used_m    = int'(wr_fill);
    rd_live_m = rd_on_m && (free_m > 0);
    wr_live_m = wr_on_m && (used_m > 0);
    rd_pre_m  = rd_on_m && (rd_deep ? free_m >= 4 : free_m >= 1);
    wr_pre_m  = wr_on_m && (wr_deep ? used_m >= 4 : used_m >= 1);
    e_rd = rst_n && (own_m == 1 ? rd_live_m : (own_m == 0 && rd_pre_m));
    e_wr = rst_n && (own_m == 2 ? wr_live_m : (own_m == 0 && wr_pre_m));
    e_rc = rst_n && own_m == 1 && gnt && rd_live_m;
    e_wc = rst_n && own_m == 2 && gnt && wr_live_m;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_m <= 0;
    else if (own_m == 0) begin
      if (gnt && e_rd) own_m <= 1;
      else if (gnt && e_wr) own_m <= 2;
    end else if (own_m == 1) begin
      if (!gnt || !rd_live_m) own_m <= 0;
    end else begin
      if (!gnt || !wr_live_m) own_m <= 0;
    end
  end

  task automatic chk(string t, string nm, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(tag, "rd_req", rd_req, e_rd);
    chk(tag, "wr_req", wr_req, e_wr);
    chk("R12", "bus_req", bus_req, e_rd | e_wr);
    chk(tag, "rd_cont", rd_cont, e_rc);
    chk(tag, "wr_cont", wr_cont, e_wc);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic idle();
    local_mode = 0; rd_reg_en = 0; wr_reg_en = 0; rd_loc_en = 0; wr_loc_en = 0;
    rd_permit = 1; wr_permit = 1; rd_deep = 0; wr_deep = 0; gnt = 0;
    rd_fill = '0; wr_fill = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    // R1: everything would request, but reset holds outputs low
    rd_reg_en = 1; wr_reg_en = 1; wr_fill = 4'd5; gnt = 1;
    tag = "R1";
    step(3);
    idle();
    rst_n = 1;
    step(2);

    tag = "R2"; rd_reg_en = 1;
    for (int f = 0; f <= DEPTH; f++) begin rd_fill = CNT_W'(f); step(1); end
    tag = "R3"; rd_deep = 1;
    for (int f = 0; f <= DEPTH; f++) begin rd_fill = CNT_W'(f); step(1); end
    idle();
    tag = "R4"; wr_reg_en = 1;
    for (int f = 0; f <= DEPTH; f++) begin wr_fill = CNT_W'(f); step(1); end
    tag = "R5"; wr_deep = 1;
    for (int f = 0; f <= DEPTH; f++) begin wr_fill = CNT_W'(f); step(1); end
    idle();

    tag = "R6";
    local_mode = 1; rd_reg_en = 1; rd_loc_en = 0; step(1);
    rd_loc_en = 1; rd_reg_en = 0; step(1);
    local_mode = 0; step(1);
    wr_fill = 4'd3; local_mode = 1; wr_loc_en = 1; wr_reg_en = 0; step(1);
    wr_loc_en = 0; wr_reg_en = 1; step(1);
    idle();

    tag = "R7";
    rd_reg_en = 1; rd_permit = 0; step(1);
    wr_reg_en = 1; wr_fill = 4'd6; wr_permit = 0; step(1);
    rd_permit = 1; step(1);
    idle();

    tag = "R8";
    rd_reg_en = 1; rd_deep = 1; rd_fill = 4'd2; gnt = 1; step(1);
    rd_fill = 4'd5; step(1);
    rd_fill = 4'd7; step(1);
    tag = "R9"; rd_fill = 4'd8; step(1);
    step(1);
    idle();
    tag = "R8";
    wr_reg_en = 1; wr_deep = 1; wr_fill = 4'd6; gnt = 1; step(1);
    wr_fill = 4'd2; step(1);
    wr_fill = 4'd1; step(1);
    tag = "R9"; wr_fill = 4'd0; step(2);
    idle();

    tag = "R9";
    rd_reg_en = 1; gnt = 1; rd_fill = 4'd3; step(2);
    rd_reg_en = 0; step(2);
    idle();

    tag = "R10";
    rd_reg_en = 1; rd_deep = 1; rd_fill = 4'd1; gnt = 1; step(2);
    rd_fill = 4'd6; step(1);
    gnt = 0; step(2);
    rd_fill = 4'd4; step(1);
    gnt = 1; step(1);
    idle();

    tag = "R11";
    rd_reg_en = 1; wr_reg_en = 1; wr_fill = 4'd8; gnt = 1; step(1);
    rd_fill = 4'd4; step(2);
    rd_fill = 4'd8; step(1);
    step(2);
    wr_fill = 4'd0; step(2);
    idle();
    step(2);

    finish_run();
  end
endmodule